// File: doc/BRIEF.md
# Sequential-Access Parameter RAM Port

This block lets a register bus fill and read back a parameter memory through just two registers: a control register and a data register. Writing the control register sets the transfer direction and turns automatic stepping on or off. It can also load a new start address. After that, each data-register access moves one word between the bus and the memory at the current pointer, and the pointer then advances. A whole channel's parameters therefore move with one control write followed by a burst of data accesses on consecutive cycles, with no status polling between them.

The memory holds `CHANNELS` regions of `WORDS_PER_CH` words, each `DATA_W` bits wide. Channel c's region starts at c × `WORDS_PER_CH`. Only the low `DATA_W` bits of a bus word are kept. The defaults build the wide coefficient store of 8 × 62 words of 32 bits. A second instance with `DATA_W = 5` and `WORDS_PER_CH = 14` serves as the narrow shift store. The filter datapath reads the same memory through an independent registered port.

Top module: `seqram_port`

## Requirements
- R1: After reset the control register reads 0x00004000: pointer 0, stepping enabled (bit 14), read direction (bit 12 = 0).
- R2: A control write takes bit 14 as the stepping enable, bit 12 as the direction (1 = write into memory) and bits [11:0] as a start address. The pointer is loaded only when bit 13 is set; otherwise only the mode changes. A control read returns the stepping and direction bits and the current pointer in [11:0], with bit 13 reading 0.
- R3: A data-register write in write direction stores the low `DATA_W` bits of the bus word at the pointer.
- R4: A data-register read in read direction returns the word at the pointer in the same cycle, zero-extended to 32 bits.
- R5: With stepping enabled, the pointer advances by one after each data access that matches the direction. With stepping disabled, the pointer stays where it is.
- R6: The pointer wraps from the last word (depth − 1) to 0.
- R7: A data access against the direction stores nothing and leaves the pointer unchanged. A data read of this kind returns 0.
- R8: A start address at or above the memory depth loads pointer 0.
- R9: A transfer that starts at c × `WORDS_PER_CH` and is `WORDS_PER_CH` long touches exactly channel c's words, and no word of a neighbouring channel.
- R10: `dp_rdata` shows the word at `dp_addr` one clock after the address is presented; an address at or above the depth gives 0.
- R11: Data accesses on consecutive clock cycles each take effect, with no wait cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_sel | input | 1 | 0 = control register, 1 = data register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| dp_addr | input | $clog2(CHANNELS*WORDS_PER_CH) | Datapath read address |
| dp_rdata | output | DATA_W | Datapath read word, one cycle after the address |

## Verification
The hardest case to reach is a direction mismatch at the last word. To get there, the pointer must first step through the whole depth, and the bench must then show through the control register alone that an ignored access neither stored anything nor moved the pointer. The bench drives a small configuration of 3 × 5 words of 5 bits. It fills every word in one back-to-back burst and reads past the end to cross the wrap. It rewrites a single channel in the middle and sweeps all the data back. It then parks the pointer on chosen words with stepping disabled or with the address-load bit cleared, and issues mismatched accesses there. Each of these steps is followed by a control readback and a memory readback.

// File: rtl/seqram_pkg.sv
package seqram_pkg;
  localparam int CTRL_ADDR_W = 12;
  localparam int DIR_BIT     = 12;
  localparam int INIT_BIT    = 13;
  localparam int SEQ_BIT     = 14;
  localparam logic [31:0] CTRL_RESET = 32'h0000_4000;

  typedef enum logic {
    DIR_READ  = 1'b0,
    DIR_WRITE = 1'b1
  } dir_e;

  typedef struct packed {
    logic seq;
    dir_e dir;
  } mode_t;
endpackage

// File: rtl/seqram_ctrl.sv
module seqram_ctrl
  import seqram_pkg::*;
#(
  parameter int DEPTH  = 496,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr_en,
  input  logic [31:0]       ctrl_wdata,
  input  logic              data_wr_req,
  input  logic              data_rd_req,
  output mode_t             mode_q,
  output logic [ADDR_W-1:0] ptr_q,
  output logic              acc_ok
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  mode_t                  mode_d;
  logic [ADDR_W-1:0]      ptr_d;
  logic [CTRL_ADDR_W-1:0] start;
  logic                   upd_en;

  assign start  = ctrl_wdata[CTRL_ADDR_W-1:0];
  assign acc_ok = (data_wr_req && mode_q.dir == DIR_WRITE) ||
                  (data_rd_req && mode_q.dir == DIR_READ);
  assign upd_en = ctrl_wr_en || (acc_ok && mode_q.seq);

  always_comb begin
    mode_d = mode_q;
    ptr_d  = ptr_q;
    if (ctrl_wr_en) begin
      mode_d.seq = ctrl_wdata[SEQ_BIT];
      mode_d.dir = dir_e'(ctrl_wdata[DIR_BIT]);
      if (ctrl_wdata[INIT_BIT]) begin
        if (32'(start) < DEPTH) ptr_d = start[ADDR_W-1:0];
        else                    ptr_d = '0;
      end
    end else if (acc_ok && mode_q.seq) begin
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '{seq: CTRL_RESET[SEQ_BIT], dir: dir_e'(CTRL_RESET[DIR_BIT])};
      ptr_q  <= '0;
    end else if (upd_en) begin
      mode_q <= mode_d;
      ptr_q  <= ptr_d;
    end
  end
endmodule

// File: rtl/seqram_store.sv
module seqram_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 496,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W-1:0] dp_addr,
  output logic [DATA_W-1:0] dp_rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] dp_d;

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];

  always_comb begin
    dp_d = '0;
    if (32'(dp_addr) < DEPTH) dp_d = mem_q[dp_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dp_rdata <= '0;
    else        dp_rdata <= dp_d;
  end
endmodule

// File: rtl/seqram_port.sv
module seqram_port
  import seqram_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int CHANNELS     = 8,
  parameter int WORDS_PER_CH = 62,
  localparam int DEPTH       = CHANNELS * WORDS_PER_CH,
  localparam int ADDR_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic              bus_sel,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [ADDR_W-1:0] dp_addr,
  output logic [DATA_W-1:0] dp_rdata
);
  mode_t             mode_q;
  logic [ADDR_W-1:0] cur_ptr;
  logic              cur_dir_wr;
  logic              cur_seq;
  logic              acc_ok;
  logic              ctrl_wr_en;
  logic              data_wr_req;
  logic              data_rd_req;
  logic [DATA_W-1:0] mem_word;

  assign ctrl_wr_en  = bus_en && bus_wr && !bus_sel;
  assign data_wr_req = bus_en && bus_wr && bus_sel;
  assign data_rd_req = bus_en && !bus_wr && bus_sel;
  assign cur_dir_wr  = (mode_q.dir == DIR_WRITE);
  assign cur_seq     = mode_q.seq;

  seqram_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr_en (ctrl_wr_en),
    .ctrl_wdata (bus_wdata),
    .data_wr_req(data_wr_req),
    .data_rd_req(data_rd_req),
    .mode_q     (mode_q),
    .ptr_q      (cur_ptr),
    .acc_ok     (acc_ok)
  );

  seqram_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (data_wr_req && acc_ok),
    .wr_addr (cur_ptr),
    .wr_data (bus_wdata[DATA_W-1:0]),
    .rd_addr (cur_ptr),
    .rd_data (mem_word),
    .dp_addr (dp_addr),
    .dp_rdata(dp_rdata)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_en && !bus_wr) begin
      if (!bus_sel) begin
        bus_rdata[SEQ_BIT]      = cur_seq;
        bus_rdata[DIR_BIT]      = cur_dir_wr;
        bus_rdata[ADDR_W-1:0]   = cur_ptr;
      end else if (!cur_dir_wr) begin
        bus_rdata[DATA_W-1:0]   = mem_word;
      end
    end
  end
endmodule

// File: rtl/seqram_port_chk.sv
module seqram_port_chk #(
  parameter int DEPTH  = 496,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_wr,
  input logic              bus_sel,
  input logic [31:0]       bus_rdata,
  input logic [ADDR_W-1:0] ptr,
  input logic              dir_wr,
  input logic              seq_on
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ptr) < DEPTH); // R6

  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_sel && (bus_wr == dir_wr) && seq_on) |=>
    (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1))); // R5

  AST_FIXED_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_sel && (bus_wr == dir_wr) && !seq_on) |=> $stable(ptr)); // R5

  AST_MISMATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_sel && (bus_wr != dir_wr)) |=> $stable(ptr)); // R7

  AST_MISMATCH_RD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_sel && !bus_wr && dir_wr) |-> (bus_rdata == 32'd0)); // R7

  AST_RD_ZERO_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_sel && !bus_wr) |-> ((bus_rdata >> DATA_W) == 32'd0)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> $stable(ptr)); // R2
endmodule

bind seqram_port seqram_port_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_en   (bus_en),
  .bus_wr   (bus_wr),
  .bus_sel  (bus_sel),
  .bus_rdata(bus_rdata),
  .ptr      (cur_ptr),
  .dir_wr   (cur_dir_wr),
  .seq_on   (cur_seq)
);

// File: tb/tb_seqram_port.sv
module tb_seqram_port;
  localparam int DW = 5;
  localparam int CH = 3;
  localparam int WPC = 5;
  localparam int DEPTH = CH * WPC;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_en, bus_wr, bus_sel;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [AW-1:0] dp_addr;
  logic [DW-1:0] dp_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [DW-1:0] m_mem [DEPTH];
  int m_ptr;
  bit m_seq, m_dirw;

  always #10 clk = ~clk;

  seqram_port #(.DATA_W(DW), .CHANNELS(CH), .WORDS_PER_CH(WPC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dp_addr(dp_addr), .dp_rdata(dp_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ctrl();
    return (32'(m_seq) << 14) | (32'(m_dirw) << 12) | 32'(m_ptr);
  endfunction

  function automatic logic [31:0] exp_data();
    return m_dirw ? 32'd0 : 32'(m_mem[m_ptr]);
  endfunction

  task automatic step_model();
    if (m_seq) m_ptr = (m_ptr == DEPTH - 1) ? 0 : m_ptr + 1;
  endtask

  task automatic ctrl_wr(input int addr, input bit init, input bit seq, input bit dirw);
    bus_en = 1; bus_wr = 1; bus_sel = 0;
    bus_wdata = {17'b0, seq, init, dirw, 12'(addr)};
    @(posedge clk); @(negedge clk);
    m_seq = seq; m_dirw = dirw;
    if (init) m_ptr = (addr < DEPTH) ? addr : 0;
  endtask

  task automatic data_wr(input logic [31:0] w);
    bus_en = 1; bus_wr = 1; bus_sel = 1; bus_wdata = w;
    @(posedge clk); @(negedge clk);
    if (m_dirw) begin
      m_mem[m_ptr] = w[DW-1:0];
      step_model();
    end
  endtask

  task automatic data_rd(output logic [31:0] v);
    bus_en = 1; bus_wr = 0; bus_sel = 1;
    #1 v = bus_rdata;
    @(posedge clk); @(negedge clk);
    if (!m_dirw) step_model();
  endtask

  task automatic ctrl_rd(output logic [31:0] v);
    bus_en = 1; bus_wr = 0; bus_sel = 0;
    #1 v = bus_rdata;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic idle();
    bus_en = 0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] v, e;
    rst_n = 0; bus_en = 0; bus_wr = 0; bus_sel = 0; bus_wdata = '0; dp_addr = '0;
    m_ptr = 0; m_seq = 1; m_dirw = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    ctrl_rd(v); chk("R1 reset control", v, 32'h0000_4000);

    // R3 R11 back-to-back fill of the whole memory
    ctrl_wr(0, 1, 1, 1);
    for (int i = 0; i < DEPTH; i++) data_wr(32'hDEAD_BE00 ^ 32'(i * 11 + 3));
    idle();
    ctrl_rd(v); chk("R6 pointer wrapped after fill", v, exp_ctrl());

    // R4 R6 read past the end
    ctrl_wr(0, 1, 1, 0);
    for (int i = 0; i < DEPTH + 2; i++) begin
      e = exp_data(); data_rd(v);
      chk((i >= DEPTH) ? "R6 read across wrap" : "R4 sequential read", v, e);
    end

    // R9 per-channel reads from each base
    for (int c = 0; c < CH; c++) begin
      ctrl_wr(c * WPC, 1, 1, 0);
      for (int k = 0; k < WPC; k++) begin
        e = 32'(5'((c * WPC + k) * 11 + 3) ^ 5'h00);
        data_rd(v); chk("R9 channel read", v, e);
      end
    end

    // R9 rewrite channel 1 only, then sweep all
    ctrl_wr(WPC, 1, 1, 1);
    for (int k = 0; k < WPC; k++) data_wr(32'hFFFF_FF00 | 32'(k * 5 + 17));
    ctrl_wr(0, 1, 1, 0);
    for (int i = 0; i < DEPTH; i++) begin
      e = exp_data(); data_rd(v); chk("R9 channel isolation", v, e);
    end
    idle();

    // R5 stepping disabled
    ctrl_wr(7, 1, 0, 1);
    data_wr(32'h1); data_wr(32'h2); data_wr(32'h1E);
    ctrl_rd(v); chk("R5 pointer fixed", v, exp_ctrl());
    ctrl_wr(7, 1, 0, 0);
    for (int i = 0; i < 3; i++) begin
      e = exp_data(); data_rd(v); chk("R5 repeated read", v, e);
    end
    ctrl_wr(6, 1, 1, 0);
    for (int i = 0; i < 3; i++) begin
      e = exp_data(); data_rd(v); chk("R5 neighbours untouched", v, e);
    end

    // R2 address-load bit clear keeps pointer
    ctrl_wr(12, 1, 1, 0);
    e = exp_data(); data_rd(v); chk("R4 read at 12", v, e);
    ctrl_wr(2, 0, 1, 1);
    ctrl_rd(v); chk("R2 pointer kept without load", v, exp_ctrl());
    data_wr(32'h0000_0009);
    ctrl_wr(13, 1, 1, 0);
    e = exp_data(); data_rd(v); chk("R2 write landed at kept pointer", v, e);

    // R7 mismatched accesses at the last word
    ctrl_rd(v); chk("R7 pointer at last word", v, exp_ctrl());
    data_wr(32'h0000_0015);
    ctrl_rd(v); chk("R7 write in read mode holds pointer", v, exp_ctrl());
    e = exp_data(); data_rd(v); chk("R7 write in read mode stored nothing", v, e);
    ctrl_wr(3, 1, 1, 1);
    data_rd(v); chk("R7 read in write mode returns zero", v, 32'd0);
    ctrl_rd(v); chk("R7 read in write mode holds pointer", v, exp_ctrl());

    // R8 out-of-range start addresses
    ctrl_wr(DEPTH, 1, 1, 0);
    ctrl_rd(v); chk("R8 depth start loads zero", v, exp_ctrl());
    ctrl_wr(9, 1, 1, 0);
    ctrl_wr(4095, 1, 1, 0);
    ctrl_rd(v); chk("R8 max start loads zero", v, exp_ctrl());
    idle();

    // R10 datapath port sweep
    for (int a = 0; a < (1 << AW); a++) begin
      dp_addr = AW'(a);
      @(posedge clk); @(negedge clk);
      chk("R10 datapath read", 32'(dp_rdata), (a < DEPTH) ? 32'(m_mem[a]) : 32'd0);
    end

    // R1 reset again
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    m_ptr = 0; m_seq = 1; m_dirw = 0;
    ctrl_rd(v); chk("R1 control after second reset", v, 32'h0000_4000);
    idle();
    finish_run();
  end
endmodule